// File: doc/BRIEF.md
# Speculative Branch Direction and Target Predictor with Rollback

This block sits in the fetch stage. It answers each fetch address in the same cycle with a taken or not-taken guess and a next address. Its state is split in two parts. A committed part holds a table of two-bit saturating counters and a direct-mapped target buffer. A small ring of speculative slots holds the training from branches that have been fetched but not yet resolved. The front end records each fetched branch in a slot and receives that slot's tag. A lookup blends the two parts: the newest slot that matches the counter index, or the buffer index, takes precedence over the committed entry.

The execution side later reports the real outcome against the slot tag. When the guess was right, the slot's counter value and target entry are folded into the committed part and the slot is freed. When it was wrong, the slot and every younger slot are discarded in one cycle. The committed counter then takes one saturating step from the value the slot was built on, toward the real direction. A taken outcome also writes its real target into the buffer. One cycle later the block pulses a redirect that carries the corrected fetch address. A wrong path therefore leaves no trace in the predictor.

Top module: `spec_bpred`

## Requirements
- R1: After reset every counter is weakly not-taken (value 1), every target-buffer entry is invalid, no slot is outstanding, `spec_ready` is 1, `spec_slot` is 0 and `redirect_valid` is 0.
- R2: The counter index is pc[7:2]. The buffer index is pc[5:2] and its tag is pc[31:6]. `pred_taken` is 1 exactly when the blended counter's upper bit is 1 and the blended buffer entry is valid with a matching tag. `pred_target` is then the stored target, and otherwise `fetch_pc`+4.
- R3: For both the counter and the buffer entry, the newest outstanding slot with the same index overrides the committed value, and each is selected on its own.
- R4: An accepted speculative write takes the slot at the ring tail, whose tag is shown on `spec_slot`, and tags advance modulo 4. Its counter is one saturating step of the blended counter toward `spec_taken`. A taken guess records a buffer entry for `spec_target`, and a not-taken guess records none.
- R5: A resolution that matches the guess (same direction, and the same target if taken) commits the slot's counter and, if taken, its buffer entry. It frees the slot and raises no redirect.
- R6: A resolution that differs in direction, or that is taken with a different target, discards the slot and all younger slots. The committed counter becomes one saturating step of the slot's base counter toward the real direction, and a taken outcome writes its real target into the buffer.
- R7: A mispredicted resolution raises `redirect_valid` for exactly one cycle, starting in the next cycle. `redirect_pc` is `res_target` if the branch was taken, or the branch's pc+4 if it was not.
- R8: While `redirect_valid` is 1, `pred_valid` is 0 and `spec_ready` is 0, so fetch requests and speculative writes in that cycle are ignored.
- R9: With 4 slots outstanding `spec_ready` is 0 and a speculative write changes no state.
- R10: Counters saturate at 0 and 3. A counter at 3 that sees one not-taken outcome becomes 2, which still predicts taken.
- R11: Resolutions arrive oldest first: `res_slot` always names the oldest outstanding slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_pc | input | 32 | Fetch address |
| pred_valid | output | 1 | Lookup accepted this cycle |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| spec_valid | input | 1 | Record a fetched branch speculatively |
| spec_pc | input | 32 | Address of that branch |
| spec_taken | input | 1 | Direction the front end followed |
| spec_target | input | 32 | Target the front end followed |
| spec_ready | output | 1 | A speculative write would be accepted |
| spec_slot | output | 2 | Tag of the slot the next write takes |
| res_valid | input | 1 | Branch outcome report |
| res_slot | input | 2 | Slot tag of the reported branch |
| res_taken | input | 1 | Real direction |
| res_target | input | 32 | Real target when taken |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Corrected fetch address |

## Verification
The bench trains one branch through a right guess, then through a wrong direction and then through a wrong target. A design that kept flushed slots, or that forgot to restore the committed counter, would go on predicting the abandoned path. Two branches that share a buffer entry but have different tags check that the newest slot's entry wins and that a tag mismatch falls through to pc+4. A blend that read the oldest slot, or that skipped the tag compare, would predict the other branch's target. A counter driven to 3 and then mispredicted must still predict taken, which catches a counter that wraps. The bench also fills every slot and then offers one more write, which a missing full check would accept as a wrong taken prediction. The redirect cycle is checked for the corrected address and for a fetch that is dropped.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;

  // one saturating step of a two-bit counter toward the given direction
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_committed.sv
module bp_committed
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PHT_BITS = 6,
  parameter int BTB_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHT_BITS-1:0] a_idx,
  input  logic [BTB_BITS-1:0] a_bidx,
  output ctr_t                a_ctr,
  output logic                a_bvalid,
  output logic [PC_W-BTB_BITS-3:0] a_btag,
  output logic [PC_W-1:0]     a_btgt,
  input  logic [PHT_BITS-1:0] b_idx,
  output ctr_t                b_ctr,
  input  logic                pht_we,
  input  logic [PHT_BITS-1:0] pht_widx,
  input  ctr_t                pht_wdata,
  input  logic                btb_we,
  input  logic [BTB_BITS-1:0] btb_widx,
  input  logic [PC_W-BTB_BITS-3:0] btb_wtag,
  input  logic [PC_W-1:0]     btb_wtgt
);
  localparam int PHT_N = 1 << PHT_BITS;
  localparam int BTB_N = 1 << BTB_BITS;
  localparam int TAG_W = PC_W - BTB_BITS - 2;

  ctr_t             pht [PHT_N];
  logic [BTB_N-1:0] bval;
  logic [TAG_W-1:0] btag [BTB_N];
  logic [PC_W-1:0]  btgt [BTB_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHT_N; i++) pht[i] <= CTR_RESET;
      bval <= '0;
    end else begin
      if (pht_we) pht[pht_widx] <= pht_wdata;
      if (btb_we) bval[btb_widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (btb_we) begin
      btag[btb_widx] <= btb_wtag;
      btgt[btb_widx] <= btb_wtgt;
    end
  end

  assign a_ctr    = pht[a_idx];
  assign b_ctr    = pht[b_idx];
  assign a_bvalid = bval[a_bidx];
  assign a_btag   = btag[a_bidx];
  assign a_btgt   = btgt[a_bidx];
endmodule

// File: rtl/bp_spec_slots.sv
module bp_spec_slots
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PHT_BITS = 6,
  parameter int BTB_BITS = 4,
  parameter int NSLOT    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc,
  input  logic [PC_W-1:0]        al_pc,
  input  logic                   al_taken,
  input  logic [PC_W-1:0]        al_tgt,
  input  ctr_t                   al_ctr,
  input  ctr_t                   al_base,
  input  logic                   retire,
  input  logic                   flush,
  output logic [$clog2(NSLOT):0] count,
  output logic [$clog2(NSLOT)-1:0] head,
  output logic [$clog2(NSLOT)-1:0] tail,
  input  logic [$clog2(NSLOT)-1:0] rd_slot,
  output logic [PC_W-1:0]        rd_pc,
  output logic                   rd_taken,
  output logic [PC_W-1:0]        rd_tgt,
  output ctr_t                   rd_ctr,
  output ctr_t                   rd_base,
  input  logic [PC_W-1:0]        a_pc,
  output logic                   a_hit,
  output ctr_t                   a_ctr,
  output logic                   a_bhit,
  output logic [PC_W-1:0]        a_bpc,
  output logic [PC_W-1:0]        a_btgt,
  input  logic [PC_W-1:0]        b_pc,
  output logic                   b_hit,
  output ctr_t                   b_ctr
);
  localparam int SW = $clog2(NSLOT);

  logic [PC_W-1:0] s_pc  [NSLOT];
  logic [PC_W-1:0] s_tgt [NSLOT];
  logic            s_tk  [NSLOT];
  ctr_t            s_ctr [NSLOT];
  ctr_t            s_base[NSLOT];

  function automatic logic [PHT_BITS-1:0] pht_idx(input logic [PC_W-1:0] pc);
    return pc[PHT_BITS+1:2];
  endfunction
  function automatic logic [BTB_BITS-1:0] btb_idx(input logic [PC_W-1:0] pc);
    return pc[BTB_BITS+1:2];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      tail  <= head;
      count <= '0;
    end else begin
      if (alloc)  tail <= tail + 1'b1;
      if (retire) head <= head + 1'b1;
      count <= count + (SW+1)'(alloc) - (SW+1)'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      s_pc[tail]   <= al_pc;
      s_tgt[tail]  <= al_tgt;
      s_tk[tail]   <= al_taken;
      s_ctr[tail]  <= al_ctr;
      s_base[tail] <= al_base;
    end
  end

  assign rd_pc    = s_pc[rd_slot];
  assign rd_taken = s_tk[rd_slot];
  assign rd_tgt   = s_tgt[rd_slot];
  assign rd_ctr   = s_ctr[rd_slot];
  assign rd_base  = s_base[rd_slot];

  // walk oldest to newest so the newest match is the one left standing
  always_comb begin
    a_hit = 1'b0; a_ctr = CTR_RESET;
    a_bhit = 1'b0; a_bpc = '0; a_btgt = '0;
    b_hit = 1'b0; b_ctr = CTR_RESET;
    for (int k = 0; k < NSLOT; k++) begin
      logic [SW-1:0] p;
      p = head + SW'(k);
      if ((SW+1)'(k) < count) begin
        if (pht_idx(s_pc[p]) == pht_idx(a_pc)) begin
          a_hit = 1'b1; a_ctr = s_ctr[p];
        end
        if (s_tk[p] && btb_idx(s_pc[p]) == btb_idx(a_pc)) begin
          a_bhit = 1'b1; a_bpc = s_pc[p]; a_btgt = s_tgt[p];
        end
        if (pht_idx(s_pc[p]) == pht_idx(b_pc)) begin
          b_hit = 1'b1; b_ctr = s_ctr[p];
        end
      end
    end
  end
endmodule

// File: rtl/spec_bpred.sv
module spec_bpred
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PHT_BITS = 6,
  parameter int BTB_BITS = 4,
  parameter int NSLOT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_valid,
  input  logic [PC_W-1:0]          fetch_pc,
  output logic                     pred_valid,
  output logic                     pred_taken,
  output logic [PC_W-1:0]          pred_target,
  input  logic                     spec_valid,
  input  logic [PC_W-1:0]          spec_pc,
  input  logic                     spec_taken,
  input  logic [PC_W-1:0]          spec_target,
  output logic                     spec_ready,
  output logic [$clog2(NSLOT)-1:0] spec_slot,
  input  logic                     res_valid,
  input  logic [$clog2(NSLOT)-1:0] res_slot,
  input  logic                     res_taken,
  input  logic [PC_W-1:0]          res_target,
  output logic                     redirect_valid,
  output logic [PC_W-1:0]          redirect_pc
);
  localparam int SW    = $clog2(NSLOT);
  localparam int TAG_W = PC_W - BTB_BITS - 2;
  localparam logic [SW:0] FULL = (SW+1)'(NSLOT);

  function automatic logic [TAG_W-1:0] btb_tag(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:BTB_BITS+2];
  endfunction

  // named internal events, observed by the bound checker
  logic          alloc_fire, retire_fire, flush_fire, res_live, mispredict;
  logic [SW:0]   slot_count;
  logic [SW-1:0] slot_head, slot_tail;

  ctr_t             c_ctr_a, c_ctr_b, s_ctr_a, s_ctr_b, blend_a, blend_b;
  logic             c_bval, s_hit_a, s_hit_b, s_bhit;
  logic [TAG_W-1:0] c_btag;
  logic [PC_W-1:0]  c_btgt, s_bpc, s_btgt;
  logic [PC_W-1:0]  r_pc, r_tgt;
  logic             r_taken;
  ctr_t             r_ctr, r_base;
  logic             b_val;
  logic [TAG_W-1:0] b_tag;
  logic [PC_W-1:0]  b_tgt;

  bp_committed #(.PC_W(PC_W), .PHT_BITS(PHT_BITS), .BTB_BITS(BTB_BITS)) u_commit (
    .clk, .rst_n,
    .a_idx(fetch_pc[PHT_BITS+1:2]), .a_bidx(fetch_pc[BTB_BITS+1:2]),
    .a_ctr(c_ctr_a), .a_bvalid(c_bval), .a_btag(c_btag), .a_btgt(c_btgt),
    .b_idx(spec_pc[PHT_BITS+1:2]), .b_ctr(c_ctr_b),
    .pht_we(res_live), .pht_widx(r_pc[PHT_BITS+1:2]),
    .pht_wdata(mispredict ? ctr_step(r_base, res_taken) : r_ctr),
    .btb_we(res_live && res_taken), .btb_widx(r_pc[BTB_BITS+1:2]),
    .btb_wtag(btb_tag(r_pc)), .btb_wtgt(res_target)
  );

  bp_spec_slots #(.PC_W(PC_W), .PHT_BITS(PHT_BITS), .BTB_BITS(BTB_BITS), .NSLOT(NSLOT)) u_slots (
    .clk, .rst_n,
    .alloc(alloc_fire), .al_pc(spec_pc), .al_taken(spec_taken), .al_tgt(spec_target),
    .al_ctr(ctr_step(blend_b, spec_taken)), .al_base(blend_b),
    .retire(retire_fire), .flush(flush_fire),
    .count(slot_count), .head(slot_head), .tail(slot_tail),
    .rd_slot(res_slot), .rd_pc(r_pc), .rd_taken(r_taken), .rd_tgt(r_tgt),
    .rd_ctr(r_ctr), .rd_base(r_base),
    .a_pc(fetch_pc), .a_hit(s_hit_a), .a_ctr(s_ctr_a),
    .a_bhit(s_bhit), .a_bpc(s_bpc), .a_btgt(s_btgt),
    .b_pc(spec_pc), .b_hit(s_hit_b), .b_ctr(s_ctr_b)
  );

  // blend: speculative state wins over committed state
  assign blend_a = s_hit_a ? s_ctr_a : c_ctr_a;
  assign blend_b = s_hit_b ? s_ctr_b : c_ctr_b;
  assign b_val   = s_bhit | c_bval;
  assign b_tag   = s_bhit ? btb_tag(s_bpc) : c_btag;
  assign b_tgt   = s_bhit ? s_btgt : c_btgt;

  assign pred_valid  = fetch_valid && !redirect_valid;
  assign pred_taken  = b_val && (b_tag == btb_tag(fetch_pc)) && blend_a[1];
  assign pred_target = pred_taken ? b_tgt : fetch_pc + PC_W'(4);

  // resolution
  assign res_live    = res_valid && (slot_count != '0);
  assign mispredict  = (res_taken != r_taken) || (res_taken && res_target != r_tgt);
  assign flush_fire  = res_live && mispredict;
  assign retire_fire = res_live && !mispredict;

  assign spec_ready = (slot_count != FULL) && !redirect_valid;
  assign spec_slot  = slot_tail;
  assign alloc_fire = spec_valid && spec_ready && !flush_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= flush_fire;
      if (flush_fire) redirect_pc <= res_taken ? res_target : r_pc + PC_W'(4);
    end
  end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W  = 32,
  parameter int NSLOT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PC_W-1:0]          fetch_pc,
  input logic                     pred_valid,
  input logic                     pred_taken,
  input logic [PC_W-1:0]          pred_target,
  input logic                     spec_ready,
  input logic                     res_valid,
  input logic [$clog2(NSLOT)-1:0] res_slot,
  input logic                     redirect_valid,
  input logic [$clog2(NSLOT):0]   slot_count,
  input logic [$clog2(NSLOT)-1:0] slot_head,
  input logic                     alloc_fire,
  input logic                     flush_fire
);
  localparam int SW = $clog2(NSLOT);
  localparam logic [SW:0] FULL = (SW+1)'(NSLOT);

  a_r7_redirect_single: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> (redirect_valid && slot_count == '0));

  a_r8_redirect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (!pred_valid && !spec_ready));

  a_r9_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_count == FULL) |-> !alloc_fire);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_count <= FULL);

  a_r11_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && slot_count != '0) |-> res_slot == slot_head);

  a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_taken) |-> pred_target == fetch_pc + PC_W'(4));

  a_r5_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && slot_count != '0 && !flush_fire && !alloc_fire)
      |=> slot_count == $past(slot_count) - 1'b1);
endmodule

bind spec_bpred bp_checker #(.PC_W(PC_W), .NSLOT(NSLOT)) u_bp_checker (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_target(pred_target), .spec_ready(spec_ready),
  .res_valid(res_valid), .res_slot(res_slot), .redirect_valid(redirect_valid),
  .slot_count(slot_count), .slot_head(slot_head), .alloc_fire(alloc_fire),
  .flush_fire(flush_fire)
);

// File: tb/test_spec_bpred.sv
module test_spec_bpred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid, spec_valid, spec_taken, res_valid, res_taken;
  logic [31:0] fetch_pc, spec_pc, spec_target, res_target;
  logic [1:0]  res_slot;
  logic        pred_valid, pred_taken, spec_ready, redirect_valid;
  logic [31:0] pred_target, redirect_pc;
  logic [1:0]  spec_slot;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PA = 32'h100;  // counter idx 0, buffer idx 0, tag 4
  localparam logic [31:0] PB = 32'h140;  // counter idx 16, buffer idx 0, tag 5
  localparam logic [31:0] PC = 32'h404;  // counter idx 1

  always #5 clk = ~clk;

  spec_bpred i_spec_bpred (
    .clk, .rst_n, .fetch_valid, .fetch_pc, .pred_valid, .pred_taken, .pred_target,
    .spec_valid, .spec_pc, .spec_taken, .spec_target, .spec_ready, .spec_slot,
    .res_valid, .res_slot, .res_taken, .res_target, .redirect_valid, .redirect_pc
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_pc = 0; spec_valid = 0; spec_pc = 0; spec_taken = 0;
    spec_target = 0; res_valid = 0; res_slot = 0; res_taken = 0; res_target = 0;
  endtask

  // {op, slot, pc, taken, target, exp_taken, exp_target}; op 0 fetch, 1 speculate, 2 resolve
  localparam int NV = 25;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b0, 32'h104},  // R1 R2 miss
    {2'd1, 2'd0, PA, 1'b1, 32'h200, 1'b0, 32'h0},    // R4
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h200},  // R3 slot overrides
    {2'd2, 2'd0, PA, 1'b1, 32'h200, 1'b0, 32'h0},    // R5 right guess
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h200},  // R5 committed
    {2'd1, 2'd1, PA, 1'b1, 32'h200, 1'b0, 32'h0},
    {2'd1, 2'd2, PA, 1'b0, 32'h0,   1'b0, 32'h0},
    {2'd2, 2'd1, PA, 1'b0, 32'h0,   1'b1, 32'h104},  // R6 R7 wrong direction
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b0, 32'h104},  // R6 younger gone
    {2'd1, 2'd1, PB, 1'b1, 32'h300, 1'b0, 32'h0},
    {2'd0, 2'd0, PB, 1'b0, 32'h0,   1'b1, 32'h300},  // R3
    {2'd1, 2'd2, PA, 1'b1, 32'h200, 1'b0, 32'h0},
    {2'd0, 2'd0, PB, 1'b0, 32'h0,   1'b0, 32'h144},  // R3 newest entry, R2 tag miss
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h200},
    {2'd2, 2'd1, PB, 1'b1, 32'h300, 1'b0, 32'h0},    // R5
    {2'd2, 2'd2, PA, 1'b1, 32'h280, 1'b1, 32'h280},  // R6 R7 wrong target
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h280},  // R6 real target kept
    {2'd0, 2'd0, PB, 1'b0, 32'h0,   1'b0, 32'h144},
    {2'd1, 2'd2, PA, 1'b1, 32'h280, 1'b0, 32'h0},
    {2'd2, 2'd2, PA, 1'b1, 32'h280, 1'b0, 32'h0},
    {2'd1, 2'd3, PA, 1'b1, 32'h280, 1'b0, 32'h0},    // R4 tag wraps next
    {2'd2, 2'd3, PA, 1'b1, 32'h280, 1'b0, 32'h0},
    {2'd1, 2'd0, PA, 1'b1, 32'h280, 1'b0, 32'h0},
    {2'd2, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h104},
    {2'd0, 2'd0, PA, 1'b0, 32'h0,   1'b1, 32'h280}   // R10 3 -> 2 still taken
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    fetch_valid = 1; fetch_pc = PA;
    #1;
    chk("R1 redirect", 32'(redirect_valid), 0);
    chk("R1 ready", 32'(spec_ready), 1);
    chk("R1 slot", 32'(spec_slot), 0);
    chk("R1 pred_valid", 32'(pred_valid), 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, sl;
      logic [31:0] pc, tg, et;
      logic tk, ek;
      {op, sl, pc, tk, tg, ek, et} = VEC[i];
      @(negedge clk);
      idle();
      case (op)
        2'd0: begin
          fetch_valid = 1; fetch_pc = pc; #1;
          chk($sformatf("R2 taken v%0d", i), 32'(pred_taken), 32'(ek));
          chk($sformatf("R2 target v%0d", i), pred_target, et);
        end
        2'd1: begin
          spec_valid = 1; spec_pc = pc; spec_taken = tk; spec_target = tg; #1;
          chk($sformatf("R4 slot v%0d", i), 32'(spec_slot), 32'(sl));
          chk($sformatf("R4 ready v%0d", i), 32'(spec_ready), 1);
        end
        default: begin
          res_valid = 1; res_slot = sl; res_taken = tk; res_target = tg;
          @(negedge clk);
          idle(); fetch_valid = 1; fetch_pc = PA; #1;
          chk($sformatf("R7 redirect v%0d", i), 32'(redirect_valid), 32'(ek));
          if (ek) begin
            chk($sformatf("R7 redirect_pc v%0d", i), redirect_pc, et);
            chk($sformatf("R8 fetch dropped v%0d", i), 32'(pred_valid), 0);
            chk($sformatf("R8 spec refused v%0d", i), 32'(spec_ready), 0);
          end else begin
            chk($sformatf("R5 fetch live v%0d", i), 32'(pred_valid), 1);
          end
        end
      endcase
    end

    // R7: the pulse lasts one cycle
    @(negedge clk); idle(); #1;
    chk("R7 single pulse", 32'(redirect_valid), 0);

    // R9: fill all slots (head is at 0), then offer one more write
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle();
      spec_valid = 1; spec_pc = PC; spec_taken = 0; #1;
      chk("R4 fill slot", 32'(spec_slot), 32'(k));
    end
    @(negedge clk); idle();
    spec_valid = 1; spec_pc = PB; spec_taken = 1; spec_target = 32'h500; #1;
    chk("R9 full not ready", 32'(spec_ready), 0);
    @(negedge clk); idle();
    fetch_valid = 1; fetch_pc = PB; #1;
    chk("R9 write ignored taken", 32'(pred_taken), 0);
    chk("R9 write ignored target", pred_target, 32'h144);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle();
      res_valid = 1; res_slot = 2'(k); res_taken = 0;
      @(negedge clk); idle(); #1;
      chk("R5 not-taken no redirect", 32'(redirect_valid), 0);
    end
    chk("R5 slots freed", 32'(spec_ready), 1);
    fetch_valid = 1; fetch_pc = PC; #1;
    chk("R10 floor target", pred_target, 32'h408);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule